// File: doc/BRIEF.md
# Parallel Enclosure Services Responder

This block sits on the enclosure (backplane) side of a parallel link between a disk drive and its enclosure. Seven shared select lines and one active-low services-enable line make up the link. While the drive leaves services-enable high, the block drives a static 7-bit loop identifier onto all seven lines.

When the drive pulls services-enable low, the lines change their roles. The low four lines become a data nibble whose direction the drive controls. Two of the upper lines become active-low write and read strobes driven by the drive. The remaining line becomes an active-low acknowledge that the block drives. The drive starts every transfer. The block takes in written nibbles and pairs them into bytes for a local register side. On reads it returns the nibbles of a byte supplied by that local side.

A configuration input, sampled once on the first clock edge after reset, decides whether the port is used at all. When the port is not used, every line is left undriven. All pin inputs pass through two-flop synchronizers before any edge is detected.

Top module: `encl_svc_port`

## Requirements
- R1: The configuration input `cfg_par_en` is captured on the first rising clock edge after reset is released, and later changes of it have no effect until the next reset. While the captured value is 0, `pad_oe` is 7'h00 and no byte or take pulse is produced. During reset, `pad_oe`, `rx_valid`, `tx_take` and `proto_err` are 0.
- R2: With the port enabled and services-enable (`esi_n`) high, `pad_oe` is 7'h7F and `pad_o` equals `loop_id`.
- R3: Three clock edges after `esi_n` goes low, `pad_oe` becomes 7'h10, so only line 4 (the acknowledge) is driven, and `pad_o[4]` is 1, meaning acknowledge is not asserted.
- R4: Three edges after the write strobe `pad_wr_n_i` falls, the block samples `pad_dat_i` and drives acknowledge low (`pad_o[4]`=0). Acknowledge returns high three edges after the write strobe rises.
- R5: Three edges after the read strobe `pad_rd_n_i` falls, the block drives the outgoing nibble on `pad_o[3:0]` with `pad_oe[3:0]`=4'hF. Acknowledge goes low one edge later. Three edges after the read strobe rises, acknowledge goes high while the data stays driven. One edge after that, `pad_oe[3:0]` returns to 0.
- R6: Written nibbles form bytes with the high nibble first. Three edges after the second write strobe falls, `rx_valid` is high for exactly one cycle, and `rx_byte` holds {first nibble, second nibble}.
- R7: Read nibbles come from `tx_byte`, bits [7:4] first and then bits [3:0]. `tx_take` pulses for one cycle four edges after the second read strobe rises.
- R8: If `esi_n` goes high in the middle of a byte, the transfer is aborted. Three edges later `pad_oe` is 7'h7F and `pad_o` is `loop_id` again. Both nibble pointers are cleared, so the next transfer starts at a high nibble.
- R9: If both strobes are low together, `proto_err` is set and stays set until reset. Acknowledge is not asserted. After both strobes return high, normal transfers resume.
- R10: While `esi_n` is high, strobe activity produces no acknowledge and no `rx_valid`, and the loop identifier stays on the lines.
- R11: A read nibble is taken from `tx_byte` at the moment the strobe fall is detected. A change of `tx_byte` while that nibble is being presented does not change `pad_o[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_en | input | 1 | Port-enable configuration, captured once after reset |
| loop_id | input | 7 | Loop identifier driven while services-enable is high |
| esi_n | input | 1 | Active-low services-enable from the drive |
| pad_wr_n_i | input | 1 | Line 6 input: active-low write strobe |
| pad_rd_n_i | input | 1 | Line 5 input: active-low read strobe |
| pad_dat_i | input | 4 | Lines 3..0 input: data nibble from the drive |
| pad_o | output | 7 | Output values for lines 6..0 |
| pad_oe | output | 7 | Output enables for lines 6..0 |
| tx_byte | input | 8 | Byte returned to the drive on reads |
| tx_take | output | 1 | One-cycle pulse once both nibbles of `tx_byte` have been read |
| rx_byte | output | 8 | Last byte written by the drive |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| proto_err | output | 1 | Sticky flag for simultaneous strobes |

## Verification
The bench aborts a byte after its first nibble, in both directions, and then checks that the next byte starts at a high nibble. A design that kept its nibble pointer would swap the halves of every later byte.

It asserts both strobes at once and checks that acknowledge never appears. A design that favoured one strobe would acknowledge a transfer the drive cannot complete.

It toggles the configuration input after reset and changes `tx_byte` while a nibble is on the lines. A design that sampled either one continuously would change the line direction or the returned data in mid-transfer.

It also toggles the strobes while services-enable is high. A design that acted on them would acknowledge while it should be driving the loop identifier.

// File: rtl/encl_svc_pkg.sv
package encl_svc_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAIT = 3'd1,
    ST_WACK = 3'd2,
    ST_RDRV = 3'd3,
    ST_RACK = 3'd4,
    ST_RREL = 3'd5,
    ST_HOLD = 3'd6
  } hs_state_t;

  // select one nibble of a byte: hi_sel=1 gives bits [7:4]
  function automatic logic [3:0] nib_pick(input logic [7:0] b, input logic hi_sel);
    return hi_sel ? b[7:4] : b[3:0];
  endfunction

  // pack two nibbles into a byte, first one on top
  function automatic logic [7:0] nib_join(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  // both active-low strobes asserted (levels are 1 when idle)
  function automatic logic both_low(input logic a, input logic b);
    return !a && !b;
  endfunction

endpackage

// File: rtl/encl_svc_sync.sv
module encl_svc_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= RST_VAL;
          s2 <= RST_VAL;
        end else begin
          s1 <= d_async[i];
          s2 <= s1;
        end
      end
      assign q_sync[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/encl_svc_edge.sv
module encl_svc_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/encl_svc_hs.sv
module encl_svc_hs
  import encl_svc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic esi_lvl,
  input  logic wr_lvl,
  input  logic wr_fall,
  input  logic rd_lvl,
  input  logic rd_fall,
  output logic svc_on,
  output logic ack_on,
  output logic dat_oe,
  output logic wr_ev,
  output logic rd_load,
  output logic rd_done,
  output logic abort,
  output logic proto_err
);
  hs_state_t st, nxt;
  logic      err_ev;

  always_comb begin
    nxt     = st;
    wr_ev   = 1'b0;
    rd_load = 1'b0;
    rd_done = 1'b0;
    abort   = 1'b0;
    err_ev  = 1'b0;
    if (!en) begin
      nxt = ST_OFF;
    end else if (st == ST_OFF) begin
      if (!esi_lvl) nxt = ST_WAIT;
    end else if (esi_lvl) begin
      nxt   = ST_OFF;
      abort = 1'b1;
    end else if (both_low(wr_lvl, rd_lvl) && st != ST_HOLD) begin
      nxt    = ST_HOLD;
      err_ev = 1'b1;
    end else begin
      case (st)
        ST_WAIT: begin
          if (wr_fall) begin
            nxt   = ST_WACK;
            wr_ev = 1'b1;
          end else if (rd_fall) begin
            nxt     = ST_RDRV;
            rd_load = 1'b1;
          end
        end
        ST_WACK: if (wr_lvl) nxt = ST_WAIT;
        ST_RDRV: nxt = rd_lvl ? ST_RREL : ST_RACK;
        ST_RACK: if (rd_lvl) nxt = ST_RREL;
        ST_RREL: begin
          nxt     = ST_WAIT;
          rd_done = 1'b1;
        end
        ST_HOLD: if (wr_lvl && rd_lvl) nxt = ST_WAIT;
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      proto_err <= 1'b0;
    end else begin
      st <= nxt;
      if (err_ev) proto_err <= 1'b1;
    end
  end

  assign svc_on = (st != ST_OFF);
  assign ack_on = (st == ST_WACK) || (st == ST_RACK);
  assign dat_oe = (st == ST_RDRV) || (st == ST_RACK) || (st == ST_RREL);

  // R4/R5: acknowledge only ever rises while a strobe was seen low
  a_r4_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |-> $past(!wr_lvl || !rd_lvl));

  // R9: two strobes low together never leave acknowledge asserted
  a_r9_no_ack_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_on && !wr_lvl && !rd_lvl && !esi_lvl) |=> !ack_on);

  // R8: services-enable released leaves the services role next cycle
  a_r8_abort_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_on && esi_lvl) |=> !svc_on);

  // R9: the error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err);
endmodule

// File: rtl/encl_svc_pack.sv
module encl_svc_pack
  import encl_svc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_ev,
  input  logic [3:0] wr_nib,
  input  logic       rd_load,
  input  logic       rd_done,
  input  logic [7:0] tx_byte,
  output logic [3:0] rd_nib,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       tx_take
);
  logic       wr_ptr;
  logic       rd_ptr;
  logic [3:0] hi_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= 1'b0;
      hi_hold  <= 4'h0;
      rx_byte  <= 8'h00;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (clr) begin
        wr_ptr <= 1'b0;
      end else if (wr_ev) begin
        wr_ptr <= ~wr_ptr;
        if (!wr_ptr) begin
          hi_hold <= wr_nib;
        end else begin
          rx_byte  <= nib_join(hi_hold, wr_nib);
          rx_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= 1'b0;
      rd_nib  <= 4'h0;
      tx_take <= 1'b0;
    end else begin
      tx_take <= 1'b0;
      if (clr) begin
        rd_ptr <= 1'b0;
      end else begin
        if (rd_load) rd_nib <= nib_pick(tx_byte, !rd_ptr);
        if (rd_done) begin
          rd_ptr  <= ~rd_ptr;
          tx_take <= rd_ptr;
        end
      end
    end
  end

  // R6: a byte is only reported on a nibble acceptance
  a_r6_valid_after_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(wr_ev));

  // R6: the byte pulse lasts one cycle
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: take follows the end of a read nibble
  a_r7_take_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> $past(rd_done));
endmodule

// File: rtl/encl_svc_port.sv
module encl_svc_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_par_en,
  input  logic [6:0] loop_id,
  input  logic       esi_n,
  input  logic       pad_wr_n_i,
  input  logic       pad_rd_n_i,
  input  logic [3:0] pad_dat_i,
  output logic [6:0] pad_o,
  output logic [6:0] pad_oe,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       proto_err
);
  localparam int CTL_W = 3;
  localparam int DAT_W = 4;

  logic             mode_q, cfg_done;
  logic [CTL_W-1:0] ctl_lvl;
  logic [1:0]       stb_fall;
  logic [DAT_W-1:0] dat_lvl;
  logic             svc_on, ack_on, dat_oe;
  logic             wr_ev, rd_load, rd_done, abort;
  logic [3:0]       rd_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      cfg_done <= 1'b0;
    end else if (!cfg_done) begin
      mode_q   <= cfg_par_en;
      cfg_done <= 1'b1;
    end
  end

  encl_svc_sync #(.W(CTL_W), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({esi_n, pad_wr_n_i, pad_rd_n_i}),
    .q_sync(ctl_lvl)
  );

  encl_svc_sync #(.W(DAT_W), .RST_VAL(1'b0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async(pad_dat_i),
    .q_sync(dat_lvl)
  );

  encl_svc_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl(ctl_lvl[1:0]),
    .fall(stb_fall)
  );

  encl_svc_hs u_hs (
    .clk(clk), .rst_n(rst_n), .en(mode_q),
    .esi_lvl(ctl_lvl[2]),
    .wr_lvl(ctl_lvl[1]), .wr_fall(stb_fall[1]),
    .rd_lvl(ctl_lvl[0]), .rd_fall(stb_fall[0]),
    .svc_on(svc_on), .ack_on(ack_on), .dat_oe(dat_oe),
    .wr_ev(wr_ev), .rd_load(rd_load), .rd_done(rd_done),
    .abort(abort), .proto_err(proto_err)
  );

  encl_svc_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr(abort),
    .wr_ev(wr_ev), .wr_nib(dat_lvl),
    .rd_load(rd_load), .rd_done(rd_done),
    .tx_byte(tx_byte), .rd_nib(rd_nib),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_take(tx_take)
  );

  always_comb begin
    if (!mode_q) begin
      pad_oe = 7'h00;
      pad_o  = 7'h00;
    end else if (!svc_on) begin
      pad_oe = 7'h7F;
      pad_o  = loop_id;
    end else begin
      pad_oe = {2'b00, 1'b1, {4{dat_oe}}};
      pad_o  = {2'b00, ~ack_on, rd_nib};
    end
  end

  // R1: the captured mode never moves after the first edge
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> $stable(mode_q));

  // R1: a disabled port drives nothing and reports no bytes
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (pad_oe == 7'h00 && !rx_valid && !tx_take));

  // R5: the data lines are released only after the read strobe is back high,
  // on an abort, or on a strobe clash
  a_r5_release_late: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_oe[0]) && $past(svc_on) && svc_on |-> $past(ctl_lvl[0]) || $past(!ctl_lvl[1]));
endmodule

// File: tb/encl_svc_port_tb_top.sv
module encl_svc_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_par_en = 1'b1;
  logic [6:0] loop_id = 7'h5A;
  logic       esi_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [3:0] dat = 4'h0;
  logic [7:0] tx_byte = 8'h00;
  logic [6:0] pad_o, pad_oe;
  logic       tx_take, rx_valid, proto_err;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  encl_svc_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .loop_id(loop_id),
    .esi_n(esi_n), .pad_wr_n_i(wr_n), .pad_rd_n_i(rd_n), .pad_dat_i(dat),
    .pad_o(pad_o), .pad_oe(pad_oe), .tx_byte(tx_byte), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .proto_err(proto_err)
  );

  function automatic logic [3:0] exp_nib(input logic [7:0] b, input int idx);
    return (idx == 0) ? b[7:4] : b[3:0];
  endfunction

  function automatic logic ack_seen(input logic [6:0] o, input logic [6:0] oe);
    return oe[4] && !o[4];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst_n = 1'b0; cfg_par_en = cfg;
    esi_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    wait_e(3);
    chk("R1 reset oe", pad_oe, 7'h00);
    chk("R1 reset flags", {rx_valid, tx_take, proto_err}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    wait_e(1);
  endtask

  task automatic enter_svc();
    @(negedge clk); esi_n = 1'b0;
    wait_e(3);
    chk("R3 oe in service", pad_oe, 7'h10);
    chk("R3 ack idle", pad_o[4], 1'b1);
  endtask

  task automatic leave_svc();
    @(negedge clk); esi_n = 1'b1;
    wait_e(3);
    chk("R8 oe restored", pad_oe, 7'h7F);
    chk("R8 loop id restored", pad_o, loop_id);
  endtask

  task automatic drv_write(input logic [3:0] n, input bit second, input logic [7:0] eb);
    @(negedge clk); dat = n; wr_n = 1'b0;
    wait_e(3);
    chk("R4 write ack on", ack_seen(pad_o, pad_oe), 1'b1);
    if (second) begin
      chk("R6 rx_valid", rx_valid, 1'b1);
      chk("R6 rx_byte", rx_byte, eb);
      wait_e(1);
      chk("R6 rx_valid one cycle", rx_valid, 1'b0);
    end else begin
      chk("R6 no early valid", rx_valid, 1'b0);
    end
    @(negedge clk); wr_n = 1'b1;
    wait_e(3);
    chk("R4 write ack off", ack_seen(pad_o, pad_oe), 1'b0);
  endtask

  task automatic write_byte(input logic [7:0] b);
    drv_write(exp_nib(b, 0), 1'b0, b);
    drv_write(exp_nib(b, 1), 1'b1, b);
  endtask

  task automatic drv_read(input logic [3:0] en, input bit second);
    @(negedge clk); rd_n = 1'b0;
    wait_e(3);
    chk("R5 data driven", pad_oe[3:0], 4'hF);
    chk("R7 read nibble", pad_o[3:0], en);
    chk("R5 ack not yet", ack_seen(pad_o, pad_oe), 1'b0);
    wait_e(1);
    chk("R5 ack on", ack_seen(pad_o, pad_oe), 1'b1);
    @(negedge clk); rd_n = 1'b1;
    wait_e(3);
    chk("R5 ack off", ack_seen(pad_o, pad_oe), 1'b0);
    chk("R5 data still driven", pad_oe[3:0], 4'hF);
    wait_e(1);
    chk("R5 data released", pad_oe[3:0], 4'h0);
    chk("R7 take pulse", tx_take, second);
  endtask

  task automatic read_byte(input logic [7:0] b);
    drv_read(exp_nib(b, 0), 1'b0);
    drv_read(exp_nib(b, 1), 1'b1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd20240611));

    // R1: port disabled, then config toggled without reset
    do_reset(1'b0);
    chk("R1 disabled oe", pad_oe, 7'h00);
    @(negedge clk); cfg_par_en = 1'b1; esi_n = 1'b0;
    wait_e(4);
    chk("R1 config change ignored", pad_oe, 7'h00);
    @(negedge clk); wr_n = 1'b0;
    wait_e(3);
    chk("R1 no valid when disabled", {rx_valid, pad_oe[4]}, 2'b00);
    @(negedge clk); wr_n = 1'b1; esi_n = 1'b1;

    // R2: enabled, loop identifier on the lines
    do_reset(1'b1);
    chk("R2 idle oe", pad_oe, 7'h7F);
    chk("R2 idle loop id", pad_o, loop_id);
    @(negedge clk); cfg_par_en = 1'b0; loop_id = 7'h23;
    wait_e(4);
    chk("R1 enable held", pad_oe, 7'h7F);
    chk("R2 loop id follows", pad_o, 7'h23);

    // R10: strobes without services-enable
    @(negedge clk); wr_n = 1'b0;
    wait_e(4);
    chk("R10 no ack", pad_oe, 7'h7F);
    chk("R10 no valid", rx_valid, 1'b0);
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    wait_e(4);
    chk("R10 loop id kept", pad_o, 7'h23);
    @(negedge clk); rd_n = 1'b1;
    wait_e(3);

    // directed write and read
    enter_svc();
    write_byte(8'hA5);
    write_byte(8'h0F);
    @(negedge clk); tx_byte = 8'h3C;
    read_byte(8'h3C);

    // R11: tx_byte changes while a nibble is presented
    @(negedge clk); tx_byte = 8'h96;
    @(negedge clk); rd_n = 1'b0;
    wait_e(3);
    chk("R11 nibble sampled", pad_o[3:0], 4'h9);
    @(negedge clk); tx_byte = 8'h46;
    wait_e(2);
    chk("R11 nibble held", pad_o[3:0], 4'h9);
    @(negedge clk); rd_n = 1'b1; tx_byte = 8'h96;
    wait_e(4);
    drv_read(4'h6, 1'b1);

    // R8: abort after a first write nibble, pointer cleared
    drv_write(4'hE, 1'b0, 8'h00);
    leave_svc();
    enter_svc();
    write_byte(8'h71);
    // R8: abort after a first read nibble
    @(negedge clk); tx_byte = 8'hD2;
    drv_read(4'hD, 1'b0);
    leave_svc();
    enter_svc();
    read_byte(8'hD2);

    // R9: strobe clash
    chk("R9 flag clear before", proto_err, 1'b0);
    @(negedge clk); wr_n = 1'b0; rd_n = 1'b0;
    wait_e(3);
    chk("R9 flag set", proto_err, 1'b1);
    chk("R9 no ack", ack_seen(pad_o, pad_oe), 1'b0);
    wait_e(3);
    chk("R9 still no ack", ack_seen(pad_o, pad_oe), 1'b0);
    chk("R9 no data driven", pad_oe[3:0], 4'h0);
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    wait_e(4);
    write_byte(8'hC3);
    chk("R9 flag sticky", proto_err, 1'b1);

    // random traffic with occasional aborts
    for (int i = 0; i < 30; i++) begin
      b = 8'($urandom);
      if ($urandom % 6 == 0) begin
        if ($urandom % 2 == 0) drv_write(b[3:0], 1'b0, 8'h00);
        else begin
          @(negedge clk); tx_byte = b;
          drv_read(exp_nib(b, 0), 1'b0);
        end
        leave_svc();
        enter_svc();
      end else if ($urandom % 2 == 0) begin
        write_byte(b);
      end else begin
        @(negedge clk); tx_byte = b;
        read_byte(b);
      end
    end
    leave_svc();

    // R1: reset clears the sticky flag
    do_reset(1'b1);
    chk("R1 flag cleared by reset", proto_err, 1'b0);
    finish_run();
  end
endmodule